// File: doc/BRIEF.md
# Three-Domain Control Register Bank with Atomic Wide Entries

This block is the control and status register bank of a switch device. A host reaches it through a plain 32-bit word-addressed bus with one-cycle read and write strobes. The bank holds a few chip-level control words: a boot-status word copied from pins, a chip-mode word, a soft-reset word and a per-port reset word. It also holds per-port configuration words, sticky per-port error flags that clear when read, and a 64-bit frame counter. A small table of 95-bit entries is reached as three consecutive 32-bit words.

The fields sit in three reset domains. Global fields return to their defaults only on the chip reset. Each port's fields return to their defaults on the chip reset, and for as long as that port's bit in the port-reset word is set. Frame-handler fields, which are the table, the frame counter and their staging and shadow buffers, are held cleared for as long as the frame-handler bit of the soft-reset word is set. That bit is set by the chip reset, so the frame-handler domain starts out held until software releases it.

Wide values move atomically. Reading the lowest word latches the whole value into a shadow buffer, and the higher words are then returned from that buffer. Writing the lower words only stages them. Writing the highest word commits the complete entry in one edge.

Top module: `regbank_top`

## Requirements
- R1: Address 0x000 returns the 8-bit `boot_pins` level in bits 7:0 with zeros above, and host writes to it change nothing.
- R2: Address 0x301 is an 8-bit read/write mode word with default 0x01. Address 0x300 bit 0 is the frame-handler reset bit with default 1. Address 0x318 bits NPORT-1:0 are per-port reset bits with default 0. Bits that are not implemented read 0.
- R3: Read data is registered. `hst_rdata` takes the value selected by a read strobe at the clock edge that samples that strobe, reads 0 after reset, and holds until the next read.
- R4: Address 0x320+p (p < NPORT) is port p's 16-bit read/write configuration word with default 0x00FF. It returns to the default on the chip reset and at every edge while port-reset bit p is set, and host writes to it are lost during that time.
- R5: While frame-handler reset bit 0x300[0] is set, the table, the frame counter and the staging and shadow buffers are held at zero and host writes to them are lost.
- R6: Global fields (0x300, 0x301, 0x318) change only through host writes or the chip reset. A frame-handler or port reset leaves them unchanged.
- R7: Address 0x303 holds one sticky error flag per port, set by a high `err_in[p]` at an edge. A host read returns the flags and clears them at the same edge, but an event at that same edge stays set. Writes do not clear the flags. Port-reset bit p clears flag p.
- R8: Table entry i (0..3) word w sits at 0x400+4*i+w. Writes to w=0 and w=1 go to a shared staging buffer. A write to w=2 commits {wdata[30:0], stage word 1, stage word 0} as the 95-bit entry in one edge, and a staged write alone leaves the stored entry unchanged.
- R9: A read of w=0 returns the stored entry's bits 31:0 and latches the whole entry into a shadow buffer. Reads of w=1 and w=2 return bits 63:32 and 94:64 (zero-extended) of the last latched entry, unaffected by later commits.
- R10: Each edge with `frm_evt` high adds one to a 64-bit frame counter. A read of 0x304 returns bits 31:0 and latches bits 63:32, which a read of 0x305 then returns. Reads do not clear the counter.
- R11: A read of any unmapped address, including table word 3, ports at or above NPORT and 0x302, returns 0 with no side effect. Writes to unmapped addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_rd | input | 1 | Host read strobe, one cycle per access |
| hst_addr | input | 12 | Host word address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Registered host read data |
| boot_pins | input | 8 | Boot status pin levels |
| err_in | input | NPORT | Per-port error event, one bit per port |
| frm_evt | input | 1 | Frame event, counted once per edge |

## Verification
Every result is due one edge after its cause. Read data appears at the edge that samples the read strobe. A write, a reset bit or an event changes state at the edge that samples it. A change to a reset bit takes effect on the domain's fields at the following edge. The bench drives strobes at a falling edge and removes them at the next falling edge, so each strobe spans exactly one rising edge. It compares `hst_rdata` at that second falling edge, half a period after the register has settled. Ordering cases, such as a clear-on-read racing an event or a shadow read after a new commit, are set up with the competing stimulus in that same single-edge window.

// File: rtl/regbank_pkg.sv
// Package: address map and region decode type shared by the register bank.
// Assumes a 12-bit word address and a table base aligned to its full span.
package regbank_pkg;
    localparam int          HAW     = 12;
    localparam logic [11:0] A_BOOT  = 12'h000;
    localparam logic [11:0] A_SOFT  = 12'h300;
    localparam logic [11:0] A_MODE  = 12'h301;
    localparam logic [11:0] A_ERR   = 12'h303;
    localparam logic [11:0] A_CNTLO = 12'h304;
    localparam logic [11:0] A_CNTHI = 12'h305;
    localparam logic [11:0] A_PRST  = 12'h318;
    localparam logic [11:0] A_PCFG  = 12'h320;
    localparam logic [11:0] A_TBL   = 12'h400;

    typedef enum logic [3:0] {
        RG_NONE, RG_BOOT, RG_SOFT, RG_MODE, RG_ERR,
        RG_CLO, RG_CHI, RG_PRST, RG_PCFG, RG_TBL
    } region_e;
endpackage

// File: rtl/regbank_glb.sv
// Global-domain control words (soft reset, mode, port reset) and the
// derived reset of the port and frame-handler domains.
// Assumes write enables already decoded; reset is synchronous active-low.
module regbank_glb #(
    parameter int NPORT = 4,
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_soft,
    input  logic              wr_mode,
    input  logic              wr_prst,
    input  logic [MODE_W-1:0] wd_mode,
    input  logic [NPORT-1:0]  wd_prst,
    input  logic              wd_soft,
    output logic              soft_q,
    output logic [MODE_W-1:0] mode_q,
    output logic [NPORT-1:0]  prst_q,
    output logic [NPORT-1:0]  port_dom_rst,
    output logic              fh_dom_rst
);
    localparam logic [MODE_W-1:0] MODE_DEF = MODE_W'(1);

    // Global registers: cleared only by the chip reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b1;
            mode_q <= MODE_DEF;
            prst_q <= '0;
        end else begin
            if (wr_soft) soft_q <= wd_soft;
            if (wr_mode) mode_q <= wd_mode;
            if (wr_prst) prst_q <= wd_prst;
        end
    end

    // Domain resets: ports follow chip reset or their bit, frame handler its bit.
    always_comb begin
        port_dom_rst = prst_q | {NPORT{~rst_n}};
        fh_dom_rst   = soft_q;
    end

    assert_mode_global_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_mode) |-> $stable(mode_q));
    assert_prst_global_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_prst) |-> $stable(prst_q));
endmodule

// File: rtl/regbank_cor.sv
// Sticky per-port error flags with clear-on-read.
// Assumes clr_rd is a real host read strobe; an event at the clearing edge is kept.
module regbank_cor #(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_rd,
    input  logic [NPORT-1:0] evt,
    input  logic [NPORT-1:0] port_rst,
    output logic [NPORT-1:0] flags
);
    // Flag update: keep or clear, merge new events, drop ports held in reset.
    always_ff @(posedge clk) begin
        flags <= ((clr_rd ? '0 : flags) | evt) & ~port_rst;
    end

    assert_keep_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_rd) |-> flags == ($past(evt) & ~$past(port_rst)));
    assert_no_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_rd) |-> ((flags & $past(flags)) == ($past(flags) & ~$past(port_rst))));
endmodule

// File: rtl/regbank_wide.sv
// Table of wide entries reached as 32-bit words, with a staging buffer for
// atomic commit and a shadow buffer for atomic read.
// Assumes word < NW on every strobe (decoded above) and DEPTH >= 2.
module regbank_wide #(
    parameter int ENTRY_W = 95,
    parameter int DEPTH   = 4,
    localparam int NW     = (ENTRY_W + 31) / 32,
    localparam int WB     = (NW > 1) ? $clog2(NW) : 1,
    localparam int IW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dom_rst,
    input  logic          rd,
    input  logic          wr,
    input  logic [IW-1:0] idx,
    input  logic [WB-1:0] word,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    localparam int TOPW = ENTRY_W - 32 * (NW - 1);
    localparam int PADW = 32 * NW;

    logic [DEPTH-1:0][ENTRY_W-1:0] tbl;
    logic [32*(NW-1)-1:0]          stage;
    logic [ENTRY_W-1:0]            shadow;
    logic [PADW-1:0]               live_pad, shad_pad;
    logic                          commit, stage_wr, latch;

    // Strobe classification by word position.
    always_comb begin
        commit   = wr && (int'(word) == NW - 1);
        stage_wr = wr && (int'(word) <  NW - 1);
        latch    = rd && (word == '0);
    end

    // Storage: cleared while the frame-handler domain is held.
    always_ff @(posedge clk) begin
        if (dom_rst) begin
            tbl    <= '0;
            stage  <= '0;
            shadow <= '0;
        end else begin
            if (stage_wr) stage[int'(word)*32 +: 32] <= wdata;
            if (commit)   tbl[idx] <= {wdata[TOPW-1:0], stage};
            if (latch)    shadow <= tbl[idx];
        end
    end

    // Read word: lowest from the live entry, others from the shadow.
    always_comb begin
        live_pad = '0;
        shad_pad = '0;
        live_pad[ENTRY_W-1:0] = tbl[idx];
        shad_pad[ENTRY_W-1:0] = shadow;
        rdata = (word == '0) ? live_pad[31:0] : shad_pad[int'(word)*32 +: 32];
    end

    assert_commit_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(commit) && !$past(dom_rst)) |-> $stable(tbl));
    assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(latch) && !$past(dom_rst)) |-> $stable(shadow));
    assert_fh_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dom_rst) |-> (tbl == '0 && shadow == '0));
endmodule

// File: rtl/regbank_ctr.sv
// Frame counter in the frame-handler domain with an atomic two-word read.
// Assumes CW is more than 32 and at most 64.
module regbank_ctr #(
    parameter int CW = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dom_rst,
    input  logic        evt,
    input  logic        rd_lo,
    input  logic        sel_hi,
    output logic [31:0] rdata
);
    logic [CW-1:0]    cnt;
    logic [CW-33:0]   hi_shadow;

    // Count events; latch the upper part when the lower word is read.
    always_ff @(posedge clk) begin
        if (dom_rst) begin
            cnt       <= '0;
            hi_shadow <= '0;
        end else begin
            if (evt)   cnt <= cnt + CW'(1);
            if (rd_lo) hi_shadow <= cnt[CW-1:32];
        end
    end

    // Word select for the host.
    always_comb rdata = sel_hi ? 32'(hi_shadow) : cnt[31:0];

    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt) && !$past(dom_rst)) |-> cnt == $past(cnt) + CW'(1));
    assert_hi_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rd_lo) && !$past(dom_rst)) |-> $stable(hi_shadow));
    assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dom_rst) |-> cnt == '0);
endmodule

// File: rtl/regbank_top.sv
// Register bank top: decodes host accesses, owns per-port config words,
// and registers the read data.
// Assumes hst_rd and hst_wr are never high together; NPORT <= 16.
module regbank_top #(
    parameter int NPORT     = 4,
    parameter int TBL_DEPTH = 4,
    parameter int ENTRY_W   = 95
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_wr,
    input  logic             hst_rd,
    input  logic [11:0]      hst_addr,
    input  logic [31:0]      hst_wdata,
    output logic [31:0]      hst_rdata,
    input  logic [7:0]       boot_pins,
    input  logic [NPORT-1:0] err_in,
    input  logic             frm_evt
);
    import regbank_pkg::*;

    localparam int NW   = (ENTRY_W + 31) / 32;
    localparam int WB   = (NW > 1) ? $clog2(NW) : 1;
    localparam int IW   = $clog2(TBL_DEPTH);
    localparam int TLO  = WB + IW;
    localparam logic [15:0] PCFG_DEF = 16'h00FF;

    region_e          rg;
    logic [11:0]      poff;
    logic [31:0]      rd_val, tbl_rd, ctr_rd;
    logic             soft_q, fh_dom_rst;
    logic [7:0]       mode_q;
    logic [NPORT-1:0] prst_q, port_dom_rst, err_flags;
    logic [15:0]      pcfg [NPORT];

    // Address decode into one region.
    always_comb begin
        poff = hst_addr - A_PCFG;
        rg   = RG_NONE;
        case (hst_addr)
            A_BOOT:  rg = RG_BOOT;
            A_SOFT:  rg = RG_SOFT;
            A_MODE:  rg = RG_MODE;
            A_ERR:   rg = RG_ERR;
            A_CNTLO: rg = RG_CLO;
            A_CNTHI: rg = RG_CHI;
            A_PRST:  rg = RG_PRST;
            default: begin
                if (hst_addr >= A_PCFG && poff < 12'(NPORT))
                    rg = RG_PCFG;
                else if (hst_addr[HAW-1:TLO] == A_TBL[HAW-1:TLO] &&
                         int'(hst_addr[WB-1:0]) < NW)
                    rg = RG_TBL;
            end
        endcase
    end

    regbank_glb #(.NPORT(NPORT), .MODE_W(8)) u_glb (
        .clk(clk), .rst_n(rst_n),
        .wr_soft(hst_wr && rg == RG_SOFT),
        .wr_mode(hst_wr && rg == RG_MODE),
        .wr_prst(hst_wr && rg == RG_PRST),
        .wd_mode(hst_wdata[7:0]), .wd_prst(hst_wdata[NPORT-1:0]),
        .wd_soft(hst_wdata[0]),
        .soft_q(soft_q), .mode_q(mode_q), .prst_q(prst_q),
        .port_dom_rst(port_dom_rst), .fh_dom_rst(fh_dom_rst)
    );

    regbank_cor #(.NPORT(NPORT)) u_cor (
        .clk(clk), .rst_n(rst_n),
        .clr_rd(hst_rd && rg == RG_ERR),
        .evt(err_in), .port_rst(port_dom_rst), .flags(err_flags)
    );

    regbank_wide #(.ENTRY_W(ENTRY_W), .DEPTH(TBL_DEPTH)) u_wide (
        .clk(clk), .rst_n(rst_n), .dom_rst(fh_dom_rst),
        .rd(hst_rd && rg == RG_TBL), .wr(hst_wr && rg == RG_TBL),
        .idx(hst_addr[TLO-1:WB]), .word(hst_addr[WB-1:0]),
        .wdata(hst_wdata), .rdata(tbl_rd)
    );

    regbank_ctr #(.CW(64)) u_ctr (
        .clk(clk), .rst_n(rst_n), .dom_rst(fh_dom_rst), .evt(frm_evt),
        .rd_lo(hst_rd && rg == RG_CLO), .sel_hi(rg == RG_CHI), .rdata(ctr_rd)
    );

    // Per-port configuration words in the port reset domain.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (port_dom_rst[p])
                pcfg[p] <= PCFG_DEF;
            else if (hst_wr && rg == RG_PCFG && poff == 12'(p))
                pcfg[p] <= hst_wdata[15:0];
        end

        assert_port_dom_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(port_dom_rst[p]) |-> pcfg[p] == PCFG_DEF);
    end

    // Read multiplexer; unmapped regions return zero.
    always_comb begin
        rd_val = '0;
        case (rg)
            RG_BOOT: rd_val = {24'b0, boot_pins};
            RG_SOFT: rd_val = {31'b0, soft_q};
            RG_MODE: rd_val = {24'b0, mode_q};
            RG_ERR:  rd_val = 32'(err_flags);
            RG_CLO,
            RG_CHI:  rd_val = ctr_rd;
            RG_PRST: rd_val = 32'(prst_q);
            RG_TBL:  rd_val = tbl_rd;
            RG_PCFG: begin
                for (int p = 0; p < NPORT; p++)
                    if (poff == 12'(p)) rd_val = {16'b0, pcfg[p]};
            end
            default: rd_val = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      hst_rdata <= '0;
        else if (hst_rd) hst_rdata <= rd_val;
    end

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hst_rd) && $past(rg) == RG_NONE) |-> hst_rdata == '0);
    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(hst_rd) && $past(rst_n)) |-> $stable(hst_rdata));
    assert_boot_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hst_rd) && $past(rg) == RG_BOOT) |-> hst_rdata == {24'b0, $past(boot_pins)});
endmodule

// File: tb/regbank_top_bench.sv
`timescale 1ns/100ps
module regbank_top_bench;
    localparam int NPORT = 4;
    localparam logic [1:0] OP_W = 2'b01, OP_R = 2'b10;
    localparam int NV = 60;
    // {op, addr, wdata / expected read}
    localparam logic [45:0] VEC [NV] = '{
        {OP_R, 12'h000, 32'h000000A5},  // R1
        {OP_W, 12'h000, 32'hFFFFFFFF},
        {OP_R, 12'h000, 32'h000000A5},  // R1 write ignored
        {OP_R, 12'h301, 32'h00000001},  // R2 defaults
        {OP_R, 12'h300, 32'h00000001},
        {OP_R, 12'h318, 32'h00000000},
        {OP_R, 12'h320, 32'h000000FF},  // R4 default
        {OP_R, 12'h323, 32'h000000FF},
        {OP_W, 12'h301, 32'hFFFFFFFF},
        {OP_R, 12'h301, 32'h000000FF},  // R2 width
        {OP_W, 12'h301, 32'h0000003C},
        {OP_R, 12'h301, 32'h0000003C},
        {OP_W, 12'h300, 32'h00000000},
        {OP_R, 12'h300, 32'h00000000},
        {OP_W, 12'h320, 32'h00007777},
        {OP_W, 12'h321, 32'h00001234},
        {OP_R, 12'h321, 32'h00001234},  // R4 rw
        {OP_W, 12'h318, 32'h00000002},
        {OP_R, 12'h318, 32'h00000002},
        {OP_R, 12'h321, 32'h000000FF},  // R4 port reset
        {OP_W, 12'h321, 32'h00005555},
        {OP_R, 12'h321, 32'h000000FF},  // R4 write lost
        {OP_R, 12'h320, 32'h00007777},  // R4 other port kept
        {OP_W, 12'h318, 32'h00000000},
        {OP_W, 12'h321, 32'h0000BEEF},
        {OP_R, 12'h321, 32'h0000BEEF},
        {OP_W, 12'h400, 32'h11111111},
        {OP_W, 12'h401, 32'h22222222},
        {OP_W, 12'h402, 32'hFFFFFFFF},
        {OP_R, 12'h400, 32'h11111111},  // R8 / R9
        {OP_R, 12'h401, 32'h22222222},
        {OP_R, 12'h402, 32'h7FFFFFFF},
        {OP_W, 12'h404, 32'h0000000A},
        {OP_W, 12'h405, 32'h0000000B},
        {OP_R, 12'h404, 32'h00000000},  // R8 staged only
        {OP_R, 12'h405, 32'h00000000},
        {OP_W, 12'h406, 32'h0000000C},
        {OP_R, 12'h404, 32'h0000000A},  // R8 committed
        {OP_R, 12'h405, 32'h0000000B},
        {OP_R, 12'h406, 32'h0000000C},
        {OP_R, 12'h400, 32'h11111111},  // R9 latch old
        {OP_W, 12'h400, 32'h00000033},
        {OP_W, 12'h401, 32'h00000044},
        {OP_W, 12'h402, 32'h00000055},
        {OP_R, 12'h401, 32'h22222222},  // R9 shadow unaffected
        {OP_R, 12'h402, 32'h7FFFFFFF},
        {OP_R, 12'h400, 32'h00000033},
        {OP_R, 12'h401, 32'h00000044},
        {OP_R, 12'h402, 32'h00000055},
        {OP_R, 12'h403, 32'h00000000},  // R11
        {OP_R, 12'h410, 32'h00000000},
        {OP_R, 12'h123, 32'h00000000},
        {OP_W, 12'h123, 32'hDEADBEEF},
        {OP_R, 12'h123, 32'h00000000},
        {OP_R, 12'h324, 32'h00000000},
        {OP_W, 12'h302, 32'h0000FFFF},
        {OP_R, 12'h302, 32'h00000000},
        {OP_R, 12'h301, 32'h0000003C},
        {OP_R, 12'h320, 32'h00007777},
        {OP_R, 12'h321, 32'h0000BEEF}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hst_wr = 1'b0, hst_rd = 1'b0, frm_evt = 1'b0;
    logic [11:0]      hst_addr = '0;
    logic [31:0]      hst_wdata = '0, hst_rdata;
    logic [7:0]       boot_pins = 8'hA5;
    logic [NPORT-1:0] err_in = '0;
    int               n_chk = 0, n_bad = 0;
    bit               done = 1'b0;

    always #2.5 clk = ~clk;

    regbank_top #(.NPORT(NPORT)) u_regbank_top (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .boot_pins(boot_pins), .err_in(err_in), .frm_evt(frm_evt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk); hst_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk); hst_rd = 1'b1; hst_addr = a;
        @(negedge clk); hst_rd = 1'b0;
        check(req, hst_rdata, exp);
    endtask

    task automatic pulse_err(input logic [NPORT-1:0] e);
        @(negedge clk); err_in = e;
        @(negedge clk); err_in = '0;
    endtask

    task automatic chip_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R3 reset rdata", hst_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][45:44] == OP_W) wr(VEC[i][43:32], VEC[i][31:0]);
            else rd($sformatf("vector %0d", i), VEC[i][43:32], VEC[i][31:0]);
        end

        // R3: data holds until the next read strobe
        rd("R3 read", 12'h301, 32'h3C);
        repeat (3) @(negedge clk);
        check("R3 hold", hst_rdata, 32'h3C);

        // R7: clear-on-read, same-edge event, write no clear, port reset clear
        pulse_err(4'b0101);
        rd("R7 flags", 12'h303, 32'h5);
        rd("R7 cleared", 12'h303, 32'h0);
        pulse_err(4'b0001);
        @(negedge clk); hst_rd = 1'b1; hst_addr = 12'h303; err_in = 4'b0010;
        @(negedge clk); hst_rd = 1'b0; err_in = '0;
        check("R7 race read", hst_rdata, 32'h1);
        rd("R7 race kept", 12'h303, 32'h2);
        pulse_err(4'b0100);
        wr(12'h303, 32'h0);
        rd("R7 write no clear", 12'h303, 32'h4);
        pulse_err(4'b1000);
        wr(12'h318, 32'h8);
        wr(12'h318, 32'h0);
        rd("R7 port reset clear", 12'h303, 32'h0);

        // R10: frame counter and its two-word read
        repeat (5) begin
            @(negedge clk); frm_evt = 1'b1;
        end
        @(negedge clk); frm_evt = 1'b0;
        rd("R10 low", 12'h304, 32'd5);
        rd("R10 high", 12'h305, 32'd0);
        rd("R10 no clear", 12'h304, 32'd5);
        repeat (3) begin
            @(negedge clk); frm_evt = 1'b1;
        end
        @(negedge clk); frm_evt = 1'b0;
        rd("R10 more", 12'h304, 32'd8);

        // R5 / R6: frame-handler reset clears its domain only
        wr(12'h300, 32'h1);
        rd("R5 counter", 12'h304, 32'h0);
        rd("R5 table", 12'h400, 32'h0);
        wr(12'h404, 32'h9);
        wr(12'h405, 32'h9);
        wr(12'h406, 32'h9);
        rd("R6 mode kept", 12'h301, 32'h3C);
        rd("R6 port cfg kept", 12'h321, 32'hBEEF);
        wr(12'h300, 32'h0);
        rd("R5 write lost", 12'h404, 32'h0);

        // R6 / R2 / R4: chip reset restores defaults
        wr(12'h318, 32'h5);
        chip_reset();
        rd("R6 mode default", 12'h301, 32'h01);
        rd("R2 prst default", 12'h318, 32'h0);
        rd("R4 cfg default", 12'h321, 32'hFF);
        rd("R2 soft default", 12'h300, 32'h1);
        boot_pins = 8'h3C;
        rd("R1 pin follow", 12'h000, 32'h3C);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule